// File: doc/BRIEF.md
# Dithered Two-Output PWM Timer

This block is a pulse-width timer with two outputs, A and B. Each timer cycle runs through four phases in a fixed order: dead time before A, on time of A, dead time before B, on time of B. Four compare inputs set where those phases begin and end. A mode input picks how the compares are read: as points on one shared ramp, as two ramps (one per output), or as four independent ramps (one per phase).

When the wanted period is not a whole number of clocks, a fractional dither corrects it. A 4-bit accumulator adds a step, counted in sixteenths of a clock, once per timer cycle. Its carry stretches the next cycle by one clock in a chosen set of phases. In the modes where the total cycle must keep its length, the phase after each stretched phase gives the clock back. Software sets the step to the fractional part of the desired period. The average period then tracks that fraction over many cycles.

Top module: `ptm_dither_pwm`

## Requirements
- R1: While `en` is low, the accumulator and phase counter are held cleared. One clock after `en` is sampled low, `pwm_a`, `pwm_b` and `cycle_done` are all low. The first cycle after enabling is never stretched.
- R2: Mode 0 (one ramp). Phase lengths in clocks are: dead A = a_set+1, on A = a_clr−a_set, dead B = b_set−a_clr, on B = b_clr−b_set. `pwm_a` is high only in on A and `pwm_b` only in on B. The two are never high together, and `pwm_b` never rises on the clock right after `pwm_a` was high.
- R3: Mode 1 (two ramp). Lengths are dead A = a_set+1, on A = a_clr−a_set, dead B = b_set+1, on B = b_clr−b_set.
- R4: Mode 2 (four ramp). Lengths are dead A = a_set+1, on A = a_clr+1, dead B = b_set+1, on B = b_clr+1.
- R5: At each cycle end, the 4-bit step (unit 1/16 clock) is added to the 4-bit accumulator. The remainder is kept. A carry out stretches only the following cycle.
- R6: Dither select 0 (on B). A stretched cycle has on B one clock longer in modes 0, 1 and 2.
- R7: Dither select 1 (on A and B). On A and on B each grow by one. In mode 0, dead B shrinks by one, so the total grows by 1. In modes 1 and 2, the total grows by 2.
- R8: Dither select 2 (dead B) and select 3 (dead A and B) in modes 0 and 1. Each selected dead time grows by one and the on time after it shrinks by one. The total length is unchanged.
- R9: Dither select 2 and select 3 in mode 2. The selected dead times grow by one each, so the total grows by 1 or 2.
- R10: Mode 3 (dual slope code) runs the mode 0 timing, and the dither never changes any phase length.
- R11: `cycle_done` is high for exactly one clock, on the last clock of on B, with `pwm_b` high.
- R12: In mode 0 with a 133-clock period and step 5, the first 48 cycles together take 48×133+14 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low holds the timer cleared |
| mode | input | 2 | 0 one ramp, 1 two ramp, 2 four ramp, 3 dual slope (no dither) |
| dith_sel | input | 2 | 0 on B, 1 on A and B, 2 dead B, 3 dead A and B |
| dith_step | input | DW | Fractional step per cycle in 1/16 clock |
| a_set_cmp | input | CW | Compare ending dead time A |
| a_clr_cmp | input | CW | Compare ending on time A |
| b_set_cmp | input | CW | Compare ending dead time B |
| b_clr_cmp | input | CW | Compare ending on time B |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| cycle_done | output | 1 | One-clock pulse on the last clock of a cycle |

## Verification
The bound checker watches, on every clock, the output relations that hold in any mode. The outputs are never high together. Output B never rises straight out of output A. The cycle-end pulse is a single clock inside on time B. The outputs go quiet one clock after the enable drops. The exact phase lengths depend on the mode and select, and the carry lags by one cycle, so only the scoreboard scenarios can show them. The same holds for the long-run period average and for the dual-slope code ignoring the dither.

// File: rtl/ptm_pkg.sv
// Shared encodings for the dithered PWM timer.
// Assumes: callers compare these enums against 2-bit port values.
package ptm_pkg;

    typedef enum logic [1:0] {
        MODE_ONE  = 2'd0,
        MODE_TWO  = 2'd1,
        MODE_FOUR = 2'd2,
        MODE_DUAL = 2'd3
    } ptm_mode_e;

    typedef enum logic [1:0] {
        DSEL_ON_B    = 2'd0,
        DSEL_ON_AB   = 2'd1,
        DSEL_DEAD_B  = 2'd2,
        DSEL_DEAD_AB = 2'd3
    } ptm_dsel_e;

    typedef enum logic [1:0] {
        PH_DEAD_A = 2'd0,
        PH_ON_A   = 2'd1,
        PH_DEAD_B = 2'd2,
        PH_ON_B   = 2'd3
    } ptm_phase_e;

    localparam int NUM_PHASES = 4;

endpackage

// File: rtl/ptm_dither_acc.sv
// Fractional dither accumulator.
// Adds the step once per timer cycle (on tick_i). The carry out is held as the
// stretch flag for the whole of the next cycle.
// Assumes: tick_i is a single-clock pulse at the cycle end.
module ptm_dither_acc #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          tick_i,
    input  logic [DW-1:0] step_i,
    output logic          stretch_o
);
    localparam int SW = DW + 1;

    logic [DW-1:0] acc_q;
    logic          stretch_q;
    logic [SW-1:0] sum;

    // Widened sum so the top bit is the carry.
    always_comb sum = {1'b0, acc_q} + {1'b0, step_i};

    // Accumulate at each cycle end; clear on reset or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            acc_q     <= '0;
            stretch_q <= 1'b0;
        end else if (tick_i) begin
            acc_q     <= sum[DW-1:0];
            stretch_q <= sum[SW-1];
        end
    end

    assign stretch_o = stretch_q;

endmodule

// File: rtl/ptm_phase_len.sv
// Phase length calculator.
// Derives the four phase lengths from the compares for the selected mode.
// It then applies the dither: +1 to each selected phase, and -1 to the phase
// after it when the mode keeps the cycle length fixed.
// Assumes: compares are ordered so that every base length is at least 1.
// A zero result is forced to 1.
module ptm_phase_len
    import ptm_pkg::*;
#(
    parameter int CW = 8,
    parameter int LW = CW + 2
) (
    input  logic [1:0]                     mode_i,
    input  logic [1:0]                     sel_i,
    input  logic                           stretch_i,
    input  logic [CW-1:0]                  a_set_i,
    input  logic [CW-1:0]                  a_clr_i,
    input  logic [CW-1:0]                  b_set_i,
    input  logic [CW-1:0]                  b_clr_i,
    output logic [NUM_PHASES-1:0][LW-1:0]  len_o
);
    logic [NUM_PHASES-1:0][LW-1:0] base;
    logic [NUM_PHASES-1:0]         grow;
    logic [NUM_PHASES-1:0]         shrink;
    logic [LW-1:0] as_w, ac_w, bs_w, bc_w;
    logic          four, one_like, dith_on;

    // Widen compares and decode the mode.
    always_comb begin
        as_w     = LW'(a_set_i);
        ac_w     = LW'(a_clr_i);
        bs_w     = LW'(b_set_i);
        bc_w     = LW'(b_clr_i);
        four     = (mode_i == MODE_FOUR);
        one_like = (mode_i == MODE_ONE) || (mode_i == MODE_DUAL);
        dith_on  = stretch_i && (mode_i != MODE_DUAL);
    end

    // Base length of each phase before dithering.
    always_comb begin
        base[PH_DEAD_A] = as_w + LW'(1);
        base[PH_ON_A]   = four ? ac_w + LW'(1) : ac_w - as_w;
        base[PH_DEAD_B] = one_like ? bs_w - ac_w : bs_w + LW'(1);
        base[PH_ON_B]   = four ? bc_w + LW'(1) : bc_w - bs_w;
    end

    // Which phases gain or give back a clock in a stretched cycle.
    always_comb begin
        grow   = '0;
        shrink = '0;
        if (dith_on) begin
            unique case (sel_i)
                DSEL_ON_B: begin
                    grow[PH_ON_B] = 1'b1;
                end
                DSEL_ON_AB: begin
                    grow[PH_ON_A]     = 1'b1;
                    grow[PH_ON_B]     = 1'b1;
                    shrink[PH_DEAD_B] = one_like;
                end
                DSEL_DEAD_B: begin
                    grow[PH_DEAD_B]  = 1'b1;
                    shrink[PH_ON_B]  = !four;
                end
                default: begin
                    grow[PH_DEAD_A]  = 1'b1;
                    grow[PH_DEAD_B]  = 1'b1;
                    shrink[PH_ON_A]  = !four;
                    shrink[PH_ON_B]  = !four;
                end
            endcase
        end
    end

    // Apply the adjustment per phase and keep each length at least one clock.
    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
        logic [LW-1:0] adj;
        always_comb begin
            adj = base[p] + LW'(grow[p]) - LW'(shrink[p]);
            len_o[p] = (adj == '0) ? LW'(1) : adj;
        end
    end

endmodule

// File: rtl/ptm_phase_seq.sv
// Phase sequencer.
// Steps through dead A, on A, dead B and on B, spending len_i[p] clocks in
// each phase, and flags the last clock of on B as the cycle end.
// Assumes: every len_i entry is at least 1 and stays stable during a phase.
module ptm_phase_seq
    import ptm_pkg::*;
#(
    parameter int LW = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en_i,
    input  logic [NUM_PHASES-1:0][LW-1:0] len_i,
    output ptm_phase_e                    phase_o,
    output logic                          last_o
);
    ptm_phase_e    phase_q;
    logic [LW-1:0] cnt_q;
    logic          phase_end;

    // Last clock of the current phase.
    always_comb phase_end = (cnt_q == len_i[phase_q] - LW'(1));

    // Count within a phase, then advance; wrap after on B.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            phase_q <= PH_DEAD_A;
            cnt_q   <= '0;
        end else if (phase_end) begin
            phase_q <= ptm_phase_e'(phase_q + 2'd1);
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_q + LW'(1);
        end
    end

    assign phase_o = phase_q;
    assign last_o  = phase_end && (phase_q == PH_ON_B);

endmodule

// File: rtl/ptm_dither_pwm.sv
// Dithered two-output PWM timer (top).
// Ties together the length calculator, the phase sequencer and the fractional
// dither accumulator. The accumulator updates on the cycle-end clock, so a
// carry stretches the cycle that follows.
// Assumes: compares, mode and select change only while en is low.
module ptm_dither_pwm
    import ptm_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [1:0]    mode,
    input  logic [1:0]    dith_sel,
    input  logic [DW-1:0] dith_step,
    input  logic [CW-1:0] a_set_cmp,
    input  logic [CW-1:0] a_clr_cmp,
    input  logic [CW-1:0] b_set_cmp,
    input  logic [CW-1:0] b_clr_cmp,
    output logic          pwm_a,
    output logic          pwm_b,
    output logic          cycle_done
);
    localparam int LW = CW + 2;

    logic [NUM_PHASES-1:0][LW-1:0] len;
    ptm_phase_e                    phase;
    logic                          last;
    logic                          stretch;

    ptm_phase_len #(.CW(CW), .LW(LW)) u_len (
        .mode_i    (mode),
        .sel_i     (dith_sel),
        .stretch_i (stretch),
        .a_set_i   (a_set_cmp),
        .a_clr_i   (a_clr_cmp),
        .b_set_i   (b_set_cmp),
        .b_clr_i   (b_clr_cmp),
        .len_o     (len)
    );

    ptm_phase_seq #(.LW(LW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en),
        .len_i   (len),
        .phase_o (phase),
        .last_o  (last)
    );

    ptm_dither_acc #(.DW(DW)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .tick_i    (last),
        .step_i    (dith_step),
        .stretch_o (stretch)
    );

    // Outputs decode straight from the registered phase.
    always_comb begin
        pwm_a      = (phase == PH_ON_A);
        pwm_b      = (phase == PH_ON_B);
        cycle_done = last;
    end

endmodule

// File: rtl/ptm_dither_pwm_chk.sv
// Protocol checker for the dithered PWM timer, bound to its top.
// Assumes: synchronous active-low reset on rst_n.
module ptm_dither_pwm_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic pwm_a,
    input logic pwm_b,
    input logic cycle_done
);
    // R2
    excl_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_a && pwm_b));

    // R2
    b_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_b) |-> !$past(pwm_a));

    // R11
    done_in_on_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> pwm_b);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pwm_a && !pwm_b && !cycle_done));

endmodule

bind ptm_dither_pwm ptm_dither_pwm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .pwm_a      (pwm_a),
    .pwm_b      (pwm_b),
    .cycle_done (cycle_done)
);

// File: tb/ptm_dither_pwm_tb.sv
// Scoreboard bench: the driver pushes the expected phase lengths per cycle;
// the monitor measures each cycle at the outputs and compares at cycle_done.
module ptm_dither_pwm_tb;
    localparam int CW = 8;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en;
    logic [1:0]    mode;
    logic [1:0]    dith_sel;
    logic [DW-1:0] dith_step;
    logic [CW-1:0] a_set_cmp, a_clr_cmp, b_set_cmp, b_clr_cmp;
    logic          pwm_a, pwm_b, cycle_done;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          mon_on = 1'b0;
    int          mst = 0;
    int          mcnt [4];
    int          sum_total = 0;

    always #5 clk = ~clk;

    ptm_dither_pwm #(.CW(CW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .dith_sel(dith_sel),
        .dith_step(dith_step), .a_set_cmp(a_set_cmp), .a_clr_cmp(a_clr_cmp),
        .b_set_cmp(b_set_cmp), .b_clr_cmp(b_clr_cmp),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .cycle_done(cycle_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Expected lengths from the requirement text, packed {onB,deadB,onA,deadA}.
    function automatic logic [31:0] exp_lens(input int md, input int sel, input bit ext,
                                             input int as, input int ac, input int bs, input int bc);
        int da, oa, db, ob;
        da = as + 1;
        if (md == 2) begin
            oa = ac + 1; db = bs + 1; ob = bc + 1;
        end else if (md == 1) begin
            oa = ac - as; db = bs + 1; ob = bc - bs;
        end else begin
            oa = ac - as; db = bs - ac; ob = bc - bs;
        end
        if (ext && md != 3) begin
            case (sel)
                0: ob++;
                1: begin oa++; ob++; if (md == 0) db--; end
                2: begin db++; if (md != 2) ob--; end
                default: begin da++; db++; if (md != 2) begin oa--; ob--; end end
            endcase
        end
        return {ob[7:0], db[7:0], oa[7:0], da[7:0]};
    endfunction

    // Monitor: measure phase lengths at the outputs, compare at each cycle end.
    always @(negedge clk) begin
        if (mon_on) begin
            if (mst == 0 && pwm_a) mst = 1;
            else if (mst == 1 && !pwm_a) mst = 2;
            else if (mst == 2 && pwm_b) mst = 3;
            mcnt[mst]++;
            if (cycle_done) begin
                logic [31:0] got, expv;
                string tg;
                got = {mcnt[3][7:0], mcnt[2][7:0], mcnt[1][7:0], mcnt[0][7:0]};
                sum_total += mcnt[0] + mcnt[1] + mcnt[2] + mcnt[3];
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11 unexpected cycle end", int'(got), 0);
                end else begin
                    expv = exp_q.pop_front();
                    tg   = tag_q.pop_front();
                    check(got == expv && mst == 3, tg, int'(got), int'(expv));
                end
                mst = 0;
                for (int i = 0; i < 4; i++) mcnt[i] = 0;
            end
        end
    end

    // Driver: configure from idle, push expected cycles, run until all seen.
    task automatic run_scn(input int md, input int sel, input int step,
                           input int as, input int ac, input int bs, input int bc,
                           input int n, input string tag);
        logic [4:0] acc;
        bit ext;
        @(posedge clk); #1 en = 1'b0; mon_on = 1'b0;
        @(posedge clk); #1;
        mode = 2'(md); dith_sel = 2'(sel); dith_step = DW'(step);
        a_set_cmp = CW'(as); a_clr_cmp = CW'(ac); b_set_cmp = CW'(bs); b_clr_cmp = CW'(bc);
        acc = '0; ext = 1'b0;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(exp_lens(md, sel, ext, as, ac, bs, bc));
            tag_q.push_back(tag);
            acc = {1'b0, acc[3:0]} + 5'(step);
            ext = acc[4];
        end
        sum_total = 0; mst = 0;
        for (int i = 0; i < 4; i++) mcnt[i] = 0;
        en = 1'b1; mon_on = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        @(posedge clk); #1 en = 1'b0; mon_on = 1'b0;
    endtask

    function automatic string sel_tag(input int md, input int sel);
        if (sel == 0) return "R6 on B dither";
        if (sel == 1) return "R7 on A and B dither";
        if (md == 2)  return "R9 four ramp dead dither";
        return "R8 dead dither keeps length";
    endfunction

    initial begin
        rst_n = 1'b0; en = 1'b0; mode = '0; dith_sel = '0; dith_step = '0;
        a_set_cmp = '0; a_clr_cmp = '0; b_set_cmp = '0; b_clr_cmp = '0;
        // R1 reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!pwm_a && !pwm_b && !cycle_done, "R1 reset outputs low",
                  {pwm_a, pwm_b, cycle_done}, 0);
        end
        @(posedge clk); #1 rst_n = 1'b1;

        run_scn(0, 0, 0, 3, 9, 14, 22, 3, "R2 one ramp lengths");
        run_scn(1, 0, 0, 3, 9, 4, 10, 3, "R3 two ramp lengths");
        run_scn(2, 0, 0, 3, 5, 2, 6, 3, "R4 four ramp lengths");
        run_scn(0, 0, 7, 3, 9, 14, 22, 6, "R5 accumulator remainder");

        for (int m = 0; m < 3; m++) begin
            for (int s = 0; s < 4; s++) begin
                if (m == 0)      run_scn(m, s, 8, 3, 9, 14, 22, 4, sel_tag(m, s));
                else if (m == 1) run_scn(m, s, 8, 3, 9, 4, 10, 4, sel_tag(m, s));
                else             run_scn(m, s, 8, 3, 5, 2, 6, 4, sel_tag(m, s));
            end
        end

        run_scn(3, 1, 15, 3, 9, 14, 22, 4, "R10 dual slope code ignores dither");
        run_scn(3, 3, 15, 3, 9, 14, 22, 4, "R10 dual slope code ignores dither");

        run_scn(0, 0, 5, 10, 60, 70, 132, 48, "R12 per cycle");
        check(sum_total == 48 * 133 + 14, "R12 average period", sum_total, 48 * 133 + 14);

        // R1 disable mid-cycle quiets the outputs one clock later
        mode = 2'd0; dith_sel = 2'd0; dith_step = 4'd8;
        a_set_cmp = 8'd3; a_clr_cmp = 8'd9; b_set_cmp = 8'd14; b_clr_cmp = 8'd22;
        @(posedge clk); #1 en = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(pwm_a == 1'b1, "R2 output A high in on time", pwm_a, 1);
        @(posedge clk); #1 en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!pwm_a && !pwm_b && !cycle_done, "R1 disabled outputs low",
              {pwm_a, pwm_b, cycle_done}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule